// File: doc/BRIEF.md
# I2C Register-File Target with Dual Index Addressing

This block is an I2C bus target that holds a small bank of 8-bit control registers and presents their contents on a flat parallel bus to neighbouring control logic. A bus host reaches the bank through two kinds of transfer. Block transfers always begin at register 0 and step through the bank. Byte-data transfers touch one register chosen by the command byte. In byte-data mode the command value is one greater than the register index, so register N is reached with command 0 in block mode and with command N+1 in byte mode.

SCL and SDA are brought into the system clock domain through a synchronizer chain. Bus edges, START and STOP are found from the synchronized levels. The system clock must run at least eight times faster than SCL. SDA is open drain: the block only ever pulls the line low, through `sda_oe`. Clock stretching, 10-bit addressing and general call are not handled.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset the registers hold 00h, E0h, 03h, 03h, FEh, 02h, FFh and 06h for indices 0 to 7. Register i appears on `regs_o[8i+7:8i]`, and `sda_oe` is low.
- R2: The target answers only to the 7-bit address 69h (address byte D2h to write, D3h to read). It ACKs by pulling SDA low during the ninth clock. Any other address is NACKed, and every later byte is ignored and not acknowledged until the next START or STOP.
- R3: A write whose command byte is 00h is a block write. The next byte is a count, and the data bytes after it are stored in registers 0, 1, 2 and so on. Data bytes beyond the count, or beyond the last register, are acknowledged but dropped.
- R4: A write whose command byte C lies in 1..8 is a byte-data write. It stores only the first data byte, into register C-1. Further data bytes in the same transfer are acknowledged but dropped.
- R5: A command byte above 8 selects no register. Data written after it is ignored, and a later read returns FFh for every byte.
- R6: After a 00h command, a read transfer first returns the count 8. It then returns registers 0 to 7 in order, and FFh for any byte past the last register.
- R7: After a command C in 1..8, every byte of a read transfer returns register C-1.
- R8: Read-only bits keep their reset value whatever is written. These are all of register 7 (the identification value 06h), bits 4:0 of register 1 and bit 5 of register 5.
- R9: When the host NACKs a read byte, the target stops driving SDA and leaves it released until the next START or STOP.
- R10: The target only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | Pull SDA low when high (open-drain drive) |
| regs_o | output | NREG*8 | Register contents, register i at bits 8i+7:8i |

## Verification
The embedded properties are checked on every clock. They cover the following: the acknowledge state is never entered for a foreign address; SDA drive only starts while SCL is low; SDA stays released once a read has been refused; block writes advance the index by one per stored byte; a byte-data write stores exactly once; and read-only bits never leave their reset values. Only the bench scenarios can show the things that depend on whole transfers. These are the shifted index between the two modes, the count limit of block writes, the order and contents of block reads with FFh padding, the FFh answer after an invalid command, and the reset values on the bus. The bench shows these by comparing the bus with a behavioural model and by checking every byte read back.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_AACK, L_WRX, L_WACK, L_RDX, L_RACK, L_HOLD
  } link_st_t;

  typedef enum logic [1:0] {M_BLOCK, M_BYTE, M_BAD} acc_mode_t;

  typedef enum logic [1:0] {P_CMD, P_CNT, P_DATA} wr_phase_t;

  function automatic logic [7:0] reg_reset_val(input int unsigned idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'hE0;
      2:       return 8'h03;
      3:       return 8'h03;
      4:       return 8'hFE;
      5:       return 8'h02;
      6:       return 8'hFF;
      7:       return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_ro_mask(input int unsigned idx);
    case (idx)
      1:       return 8'h1F;
      5:       return 8'h20;
      7:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_s    = scl_p[STAGES-1];
  assign sda_s    = sda_p[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cs_link.sv
module i2cs_link
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] tx_data,
  output logic       adr_valid,
  output logic       adr_rw,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       tx_load,
  output logic       sda_oe
);

  link_st_t   st, st_n;
  logic [2:0] cnt, cnt_n;
  logic [6:0] sh, sh_n;
  logic [6:0] tx, tx_n;
  logic       oe, oe_n;
  logic       got, got_n;
  logic       hit, hit_n;
  logic       rw, rw_n;
  logic       mack, mack_n;

  assign rx_data = {sh, sda_s};
  assign adr_rw  = sda_s;
  assign sda_oe  = oe;

  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; tx_n = tx; oe_n = oe;
    got_n = got; hit_n = hit; rw_n = rw; mack_n = mack;
    adr_valid = 1'b0;
    rx_valid  = 1'b0;
    tx_load   = 1'b0;
    if (stop_ev) begin
      st_n = L_IDLE; oe_n = 1'b0; got_n = 1'b0;
    end else if (start_ev) begin
      st_n = L_ADDR; cnt_n = '0; oe_n = 1'b0; got_n = 1'b0;
    end else begin
      case (st)
        L_ADDR, L_WRX: begin
          if (scl_rise) begin
            sh_n  = {sh[5:0], sda_s};
            cnt_n = cnt + 3'd1;
            if (cnt == 3'd7) begin
              got_n = 1'b1;
              if (st == L_ADDR) begin
                hit_n     = (sh == DEV_ADDR);
                rw_n      = sda_s;
                adr_valid = (sh == DEV_ADDR);
              end else begin
                rx_valid = 1'b1;
              end
            end
          end else if (scl_fall && got) begin
            got_n = 1'b0;
            if (st == L_ADDR && !hit) begin
              st_n = L_HOLD;
            end else begin
              oe_n = 1'b1;
              st_n = (st == L_ADDR) ? L_AACK : L_WACK;
            end
          end
        end
        L_AACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw) begin
              tx_load = 1'b1;
              tx_n    = tx_data[6:0];
              oe_n    = ~tx_data[7];
              st_n    = L_RDX;
            end else begin
              oe_n = 1'b0;
              st_n = L_WRX;
            end
          end
        end
        L_WACK: begin
          if (scl_fall) begin
            oe_n = 1'b0; cnt_n = '0; st_n = L_WRX;
          end
        end
        L_RDX: begin
          if (scl_fall) begin
            if (cnt == 3'd7) begin
              oe_n = 1'b0;
              st_n = L_RACK;
            end else begin
              oe_n  = ~tx[6];
              tx_n  = {tx[5:0], 1'b0};
              cnt_n = cnt + 3'd1;
            end
          end
        end
        L_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx_load = 1'b1;
              tx_n    = tx_data[6:0];
              oe_n    = ~tx_data[7];
              cnt_n   = '0;
              st_n    = L_RDX;
            end else begin
              st_n = L_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= L_IDLE; cnt <= '0; sh <= '0; tx <= '0; oe <= 1'b0;
      got <= 1'b0; hit <= 1'b0; rw <= 1'b0; mack <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; sh <= sh_n; tx <= tx_n; oe <= oe_n;
      got <= got_n; hit <= hit_n; rw <= rw_n; mack <= mack_n;
    end
  end

  assert_ack_own_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == L_AACK) |-> hit);

  assert_drive_on_low_scl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> !scl_s);

  assert_quiet_after_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == L_HOLD) |-> !oe);

endmodule

// File: rtl/i2cs_xact.sv
module i2cs_xact
  import i2cs_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adr_valid,
  input  logic              adr_rw,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              tx_load,
  input  logic [NREG*8-1:0] rd_vals,
  output logic              wr_en,
  output logic [$clog2(NREG):0] wr_idx,
  output logic [7:0]        wr_data,
  output logic [7:0]        tx_data
);

  localparam int PW = $clog2(NREG) + 1;
  localparam logic [PW-1:0] LAST = PW'(NREG);

  acc_mode_t     mode, mode_n;
  wr_phase_t     phase, phase_n;
  logic [PW-1:0] sel, sel_n, wptr, wptr_n, rptr, rptr_n;
  logic [7:0]    remain, remain_n;
  logic          rfirst, rfirst_n;
  logic [7:0]    rsel;

  always_comb begin
    rsel = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (rptr == PW'(i)) rsel = rd_vals[i*8 +: 8];
  end

  always_comb begin
    if (mode == M_BAD)  tx_data = 8'hFF;
    else if (rfirst)    tx_data = 8'(NREG);
    else                tx_data = rsel;
  end

  assign wr_idx  = wptr;
  assign wr_data = rx_data;

  always_comb begin
    mode_n = mode; phase_n = phase; sel_n = sel; wptr_n = wptr;
    rptr_n = rptr; remain_n = remain; rfirst_n = rfirst;
    wr_en = 1'b0;
    if (adr_valid && !adr_rw) phase_n = P_CMD;
    if (adr_valid && adr_rw) begin
      rptr_n   = (mode == M_BYTE) ? sel : '0;
      rfirst_n = (mode == M_BLOCK);
    end
    if (tx_load) begin
      if (rfirst) rfirst_n = 1'b0;
      else if (mode == M_BLOCK && rptr < LAST) rptr_n = rptr + PW'(1);
    end
    if (rx_valid) begin
      case (phase)
        P_CMD: begin
          if (rx_data == 8'h00) begin
            mode_n = M_BLOCK; wptr_n = '0; remain_n = '0; phase_n = P_CNT;
          end else if (rx_data <= 8'(NREG)) begin
            mode_n   = M_BYTE;
            sel_n    = PW'(rx_data - 8'd1);
            wptr_n   = PW'(rx_data - 8'd1);
            remain_n = 8'd1;
            phase_n  = P_DATA;
          end else begin
            mode_n = M_BAD; remain_n = '0; phase_n = P_DATA;
          end
        end
        P_CNT: begin
          remain_n = rx_data; phase_n = P_DATA;
        end
        default: begin
          if (remain != 8'd0) begin
            remain_n = remain - 8'd1;
            if (wptr < LAST) begin
              wr_en  = 1'b1;
              wptr_n = wptr + PW'(1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_BLOCK; phase <= P_CMD; sel <= '0; wptr <= '0;
      rptr <= '0; remain <= '0; rfirst <= 1'b0;
    end else begin
      mode <= mode_n; phase <= phase_n; sel <= sel_n; wptr <= wptr_n;
      rptr <= rptr_n; remain <= remain_n; rfirst <= rfirst_n;
    end
  end

  assert_block_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == M_BLOCK) |=> (wptr == $past(wptr) + PW'(1)));

  assert_single_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == M_BYTE) |=> (remain == 8'd0));

endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank
  import i2cs_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [$clog2(NREG):0] wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NREG*8-1:0]     q_o
);

  localparam int PW = $clog2(NREG) + 1;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] DEF = reg_reset_val(g);
    localparam logic [7:0] RO  = reg_ro_mask(g);
    logic [7:0] q, d;
    logic       en;

    assign en = wr_en && (wr_idx == PW'(g));

    always_comb begin
      d = (wr_data & ~RO) | (q & RO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= DEF;
      else if (en) q <= d;
    end

    assign q_o[g*8 +: 8] = q;

    if (RO != 8'h00) begin : g_ro_chk
      assert_ro_bits_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q & RO) == (DEF & RO));
    end
  end

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter int         NREG        = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);

  localparam int PW = $clog2(NREG) + 1;

  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic adr_valid, adr_rw, rx_valid, tx_load, wr_en;
  logic [7:0] rx_data, tx_data, wr_data;
  logic [PW-1:0] wr_idx;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cs_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_s), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .tx_data(tx_data), .adr_valid(adr_valid), .adr_rw(adr_rw),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_load(tx_load), .sda_oe(sda_oe)
  );

  i2cs_xact #(.NREG(NREG)) u_xact (
    .clk(clk), .rst_n(rst_s), .adr_valid(adr_valid), .adr_rw(adr_rw),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_load(tx_load), .rd_vals(regs_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .tx_data(tx_data)
  );

  i2cs_regbank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .q_o(regs_o)
  );

endmodule

// File: tb/tb_i2c_regfile_target.sv
module tb_i2c_regfile_target;
  localparam int NREG = 8;
  localparam int Q    = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl, m_low, dut_oe, sda_line;
  logic [NREG*8-1:0] regs;
  assign sda_line = !(m_low || dut_oe);

  i2c_regfile_target #(.NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(dut_oe), .regs_o(regs)
  );

  int n_cmp = 0, n_bad = 0, viol = 0;
  int model[NREG];
  int txq[$];
  bit idle_cmp = 0;
  string cur_req = "R1";
  logic prev_oe = 1'b0;

  function automatic int def_val(int i);
    case (i)
      0: return 'h00; 1: return 'hE0; 2: return 'h03; 3: return 'h03;
      4: return 'hFE; 5: return 'h02; 6: return 'hFF; 7: return 'h06;
      default: return 0;
    endcase
  endfunction

  function automatic int ro_mask(int i);
    case (i)
      1: return 'h1F; 5: return 'h20; 7: return 'hFF;
      default: return 0;
    endcase
  endfunction

  function automatic void model_wr(int i, int v);
    model[i] = (v & ~ro_mask(i) & 'hFF) | (model[i] & ro_mask(i));
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  // model comparison on every clock while the bus is quiet
  always @(negedge clk) begin
    if (idle_cmp)
      for (int i = 0; i < NREG; i++)
        chk($sformatf("%s reg%0d", cur_req, i), int'(regs[i*8 +: 8]), model[i]);
    if (dut_oe && !prev_oe && scl) viol++;
    prev_oe <= dut_oe;
  end

  task automatic settle();
    idle_cmp = 1; wq(10); idle_cmp = 0;
  endtask

  task automatic bit_clk(input bit v, output bit s);
    m_low = !v; wq(Q);
    scl = 1'b1; wq(Q/2);
    s = sda_line; wq(Q - Q/2);
    scl = 1'b0; wq(2);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b1; wq(Q); scl = 1'b0; wq(2);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input int b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], s);
    bit_clk(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit give_ack, output int b);
    bit s;
    b = 0;
    for (int i = 0; i < 8; i++) begin
      bit_clk(1'b1, s);
      b = (b << 1) | int'(s);
    end
    bit_clk(!give_ack, s);
  endtask

  task automatic wr_block(int cnt);
    bit a;
    i2c_start();
    send_byte('hD2, a); chk("R2 addr ack", a, 1);
    send_byte('h00, a); chk("R3 cmd ack", a, 1);
    send_byte(cnt, a);  chk("R3 count ack", a, 1);
    foreach (txq[k]) begin
      send_byte(txq[k], a); chk("R3 data ack", a, 1);
      if (k < cnt && k < NREG) model_wr(k, txq[k]);
    end
    i2c_stop(); settle();
  endtask

  task automatic wr_byte(int cmd);
    bit a;
    i2c_start();
    send_byte('hD2, a); chk("R2 addr ack", a, 1);
    send_byte(cmd, a);  chk("R4 cmd ack", a, 1);
    foreach (txq[k]) begin
      send_byte(txq[k], a); chk("R4 data ack", a, 1);
      if (k == 0 && cmd >= 1 && cmd <= NREG) model_wr(cmd - 1, txq[k]);
    end
    i2c_stop(); settle();
  endtask

  task automatic rd_seq(int cmd, int n);
    bit a;
    int b, e;
    i2c_start();
    send_byte('hD2, a); chk("R2 addr ack", a, 1);
    send_byte(cmd, a);  chk("R2 cmd ack", a, 1);
    i2c_start();
    send_byte('hD3, a); chk("R2 read addr ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      if (cmd == 0)         e = (k == 0) ? NREG : ((k - 1 < NREG) ? model[k-1] : 'hFF);
      else if (cmd <= NREG) e = model[cmd-1];
      else                  e = 'hFF;
      chk($sformatf("%s read byte %0d", cur_req, k), b, e);
    end
    wq(4);
    chk("R9 sda released after nack", int'(dut_oe), 0);
    wq(Q);
    chk("R9 sda still released", int'(dut_oe), 0);
    i2c_stop(); settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit a;
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = def_val(i);
    wq(5); rst_n = 1'b1; wq(6);

    cur_req = "R1";
    for (int i = 0; i < NREG; i++)
      chk($sformatf("R1 reset reg%0d", i), int'(regs[i*8 +: 8]), def_val(i));
    chk("R1 reset sda_oe", int'(dut_oe), 0);

    cur_req = "R2";
    i2c_start();
    send_byte('hA4, a); chk("R2 foreign addr nack", a, 0);
    send_byte('h02, a); chk("R2 byte after nack", a, 0);
    send_byte('h55, a); chk("R2 byte after nack", a, 0);
    i2c_stop(); settle();
    i2c_start();
    send_byte('hD4, a); chk("R2 near addr nack", a, 0);
    i2c_stop(); settle();

    cur_req = "R3";
    txq.delete(); txq.push_back('h11); txq.push_back('h22); txq.push_back('h33); txq.push_back('h44);
    wr_block(3);
    txq.delete();
    for (int i = 0; i < 9; i++) txq.push_back('hA0 + i);
    wr_block(12);

    cur_req = "R4";
    txq.delete(); txq.push_back('h5A); txq.push_back('h77);
    wr_byte(5);
    txq.delete(); txq.push_back('h3C);
    wr_byte(1);

    cur_req = "R8";
    txq.delete(); txq.push_back('hFF);
    wr_byte(6);
    txq.delete(); txq.push_back('h00);
    wr_byte(8);
    txq.delete(); txq.push_back('h55);
    wr_byte(2);

    cur_req = "R5";
    txq.delete(); txq.push_back('h99); txq.push_back('h66);
    wr_byte(9);
    txq.delete(); txq.push_back('h12);
    wr_byte('hFF);
    rd_seq(12, 2);

    cur_req = "R6";
    rd_seq(0, 10);

    cur_req = "R7";
    rd_seq(5, 3);
    rd_seq(2, 2);

    chk("R10 drive begins only with scl low", viol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule